// File: doc/BRIEF.md
# Branch Resolution Unit

A purely combinational execution unit for a 64-bit processor that resolves branch operations in the same cycle its operands arrive. It receives a decoded branch operation (kind, immediate displacement fields, absolute-address flag, branch-options field, condition-bit index, register-branch selector field, link flag and 32-bit counter mode), the address of the current instruction, the 4-bit condition field already picked out of the condition register, the count register and a second special-register value used as a branch target. It returns the next instruction address, the return address for the link register and the updated count, each paired with its own valid flag. An opaque operation context word travels from input to output unchanged.

Three branch kinds are handled. The first is an unconditional branch with a 24-bit displacement. The second is a conditional branch with a 14-bit displacement. The third is a conditional branch to a register. A conditional branch is taken when a condition-bit test and a count test both pass. Either test can be disabled by bits of the options field. The count can also be decremented, and in 32-bit mode only its low half is tested.

Top module: `br_resolve_unit`

## Requirements
- R1: `op_kind` is encoded as 0 = no branch, 1 = unconditional immediate, 2 = conditional immediate, 3 = conditional register. For kind 0 all three valid flags are low. In every case, each data output whose valid flag is low reads zero, and `ctx_out` equals `ctx_in`.
- R2: For kind 1, `next_vld` is 1. The offset is `f_li` (24 bits) sign-extended and multiplied by 4. With `f_aa`=1 the next address is the offset itself; with `f_aa`=0 it is `cur_addr` plus the offset, modulo 2^64.
- R3: For kinds 1 to 3, `link_vld` equals `link_en`. When `link_vld` is high, `link_addr` is `cur_addr`+4 modulo 2^64.
- R4: For kind 1, `cnt_vld` is 0.
- R5: The condition test passes when `f_bo[4]` is 1, or when the selected condition bit equals `f_bo[3]`. `cr_field` holds the field numbered by `f_bi[4:2]`, with its bit 3 as the first (most significant) condition bit. The selected bit is therefore `cr_field[3 - f_bi[1:0]]`.
- R6: For kinds 2 and 3 with `f_bo[2]`=0, `cnt_vld` is 1 and `cnt_out` is `cnt_in`-1 modulo 2^64. With `f_bo[2]`=1, `cnt_vld` is 0.
- R7: The count test passes when `f_bo[2]` is 1, or when ("tested count is non-zero" XOR `f_bo[1]`) is true. The tested count is the incoming `cnt_in`. When `mode32`=1, only `cnt_in[31:0]` is tested.
- R8: For kinds 2 and 3, `next_vld` is 1 exactly when both the condition test and the count test pass.
- R9: For kind 2, the offset is `f_bd` (14 bits) sign-extended and multiplied by 4. It forms the target with the same absolute/relative choice by `f_aa` as in R2.
- R10: For kind 3, the target is `cnt_in` when `f_xo[9]`=1 and `f_xo[5]`=0, and `tgt_in` otherwise (bit 9 is the most significant bit of the 10-bit field). Target bits 1:0 are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | Branch kind (R1 encoding) |
| f_li | input | 24 | Unconditional displacement, in words |
| f_bd | input | 14 | Conditional displacement, in words |
| f_aa | input | 1 | Absolute target when 1 |
| f_bo | input | 5 | Branch options |
| f_bi | input | 5 | Condition bit index |
| f_xo | input | 10 | Register-branch selector field |
| link_en | input | 1 | Request a return address |
| mode32 | input | 1 | Test only the low half of the count |
| ctx_in | input | 8 | Operation context |
| cur_addr | input | 64 | Current instruction address |
| cr_field | input | 4 | Selected condition field |
| cnt_in | input | 64 | Count register value |
| tgt_in | input | 64 | Second register-branch target |
| next_addr | output | 64 | Next instruction address |
| next_vld | output | 1 | Branch taken |
| link_addr | output | 64 | Return address |
| link_vld | output | 1 | Link register write |
| cnt_out | output | 64 | Decremented count |
| cnt_vld | output | 1 | Count register write |
| ctx_out | output | 8 | Context passed through |

## Verification
The main sweep walks every branch kind, every options-field value, every bit position inside the condition field and every condition-field value. This separates the condition bit that was tested from its neighbours and covers each enable/invert combination of both tests. Counts are drawn from a small set: zero, one, a value with only the upper half set, all ones, and random values. This set distinguishes a 32-bit zero test from a 64-bit one and a test of the incoming count from a test of the decremented count. Directed vectors apply the most negative displacements near address zero to expose sign-extension and wrap-around faults. Selector values of the register branch that differ only in bit 5 or only in bit 9 show which target is chosen.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BK_NONE     = 2'd0,
    BK_IMM      = 2'd1,
    BK_COND_IMM = 2'd2,
    BK_COND_REG = 2'd3
  } br_kind_e;
endpackage

// File: rtl/br_cond_check.sv
module br_cond_check #(
  parameter int FLD_W = 4
) (
  input  logic [4:0]         bo,
  input  logic [1:0]         bit_sel,
  input  logic [FLD_W-1:0]   cr_field,
  output logic               cond_ok
);
  localparam int TOP = FLD_W - 1;
  logic picked;

  // R5: first condition bit of the field sits at its most significant end
  always_comb begin
    picked  = cr_field[TOP - int'(bit_sel)];
    cond_ok = bo[4] | (picked == bo[3]);
  end

  always_comb begin
    if (bo[4]) assert_cond_forced_R5: assert (cond_ok);
  end
endmodule

// File: rtl/br_count_unit.sv
module br_count_unit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cnt_in,
  input  logic [4:0]      bo,
  input  logic            mode32,
  output logic [XLEN-1:0] cnt_dec,
  output logic            cnt_ok
);
  localparam int HALF = XLEN / 2;
  logic lo_nz, hi_nz, tested_nz;

  assign cnt_dec = cnt_in - XLEN'(1);   // R6
  assign lo_nz   = |cnt_in[HALF-1:0];

  generate
    if (XLEN > HALF) begin : g_hi
      assign hi_nz = |cnt_in[XLEN-1:HALF];
    end else begin : g_nohi
      assign hi_nz = 1'b0;
    end
  endgenerate

  // R7: in 32-bit mode only the low half counts
  always_comb begin
    tested_nz = mode32 ? lo_nz : (lo_nz | hi_nz);
    cnt_ok    = bo[2] | (tested_nz ^ bo[1]);
  end

  always_comb begin
    if (mode32 && cnt_in[HALF-1:0] == '0 && !bo[2] && !bo[1])
      assert_half_zero_fails_R7: assert (!cnt_ok);
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LI_W = 24,
  parameter int BD_W = 14
) (
  input  br_kind_e        kind,
  input  logic [LI_W-1:0] li,
  input  logic [BD_W-1:0] bd,
  input  logic            aa,
  input  logic            reg_sel_cnt,
  input  logic [XLEN-1:0] cur_addr,
  input  logic [XLEN-1:0] cnt_in,
  input  logic [XLEN-1:0] tgt_in,
  output logic [XLEN-1:0] target
);
  localparam int LI_PAD = XLEN - LI_W - 2;
  localparam int BD_PAD = XLEN - BD_W - 2;

  logic [XLEN-1:0] li_off, bd_off, off, imm_tgt, reg_src, reg_tgt;

  // R2 R9: sign-extend the word displacement and scale by four
  assign li_off = {{LI_PAD{li[LI_W-1]}}, li, 2'b00};
  assign bd_off = {{BD_PAD{bd[BD_W-1]}}, bd, 2'b00};

  always_comb begin
    off     = (kind == BK_IMM) ? li_off : bd_off;
    imm_tgt = aa ? off : (cur_addr + off);
    reg_src = reg_sel_cnt ? cnt_in : tgt_in;          // R10
    reg_tgt = {reg_src[XLEN-1:2], 2'b00};
    target  = (kind == BK_COND_REG) ? reg_tgt : imm_tgt;
  end

  always_comb begin
    if (kind == BK_COND_REG) assert_reg_aligned_R10: assert (target[1:0] == 2'b00);
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LI_W  = 24,
  parameter int BD_W  = 14,
  parameter int CTX_W = 8
) (
  input  logic [1:0]       op_kind,
  input  logic [LI_W-1:0]  f_li,
  input  logic [BD_W-1:0]  f_bd,
  input  logic             f_aa,
  input  logic [4:0]       f_bo,
  input  logic [4:0]       f_bi,
  input  logic [9:0]       f_xo,
  input  logic             link_en,
  input  logic             mode32,
  input  logic [CTX_W-1:0] ctx_in,
  input  logic [XLEN-1:0]  cur_addr,
  input  logic [3:0]       cr_field,
  input  logic [XLEN-1:0]  cnt_in,
  input  logic [XLEN-1:0]  tgt_in,
  output logic [XLEN-1:0]  next_addr,
  output logic             next_vld,
  output logic [XLEN-1:0]  link_addr,
  output logic             link_vld,
  output logic [XLEN-1:0]  cnt_out,
  output logic             cnt_vld,
  output logic [CTX_W-1:0] ctx_out
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  br_kind_e        kind;
  logic            cond_ok, cnt_ok, is_cond, is_br, taken;
  logic [XLEN-1:0] cnt_dec, target;
  logic            unused_fields;

  assign kind          = br_kind_e'(op_kind);
  assign unused_fields = ^{f_bi[4:2], f_xo[8:6], f_xo[4:0]};

  br_cond_check #(.FLD_W(4)) u_cond (
    .bo(f_bo), .bit_sel(f_bi[1:0]), .cr_field(cr_field), .cond_ok(cond_ok)
  );

  br_count_unit #(.XLEN(XLEN)) u_cnt (
    .cnt_in(cnt_in), .bo(f_bo), .mode32(mode32), .cnt_dec(cnt_dec), .cnt_ok(cnt_ok)
  );

  br_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .kind(kind), .li(f_li), .bd(f_bd), .aa(f_aa),
    .reg_sel_cnt(f_xo[9] & ~f_xo[5]),
    .cur_addr(cur_addr), .cnt_in(cnt_in), .tgt_in(tgt_in), .target(target)
  );

  always_comb begin
    is_cond   = (kind == BK_COND_IMM) || (kind == BK_COND_REG);
    is_br     = (kind != BK_NONE);
    taken     = (kind == BK_IMM) | (is_cond & cond_ok & cnt_ok);   // R2 R8
    next_vld  = taken;
    next_addr = taken ? target : '0;
    link_vld  = is_br & link_en;                                   // R3
    link_addr = link_vld ? (cur_addr + INSN_BYTES) : '0;
    cnt_vld   = is_cond & ~f_bo[2];                                // R4 R6
    cnt_out   = cnt_vld ? cnt_dec : '0;
    ctx_out   = ctx_in;                                            // R1
  end

  always_comb begin
    if (kind == BK_NONE)
      assert_idle_quiet_R1: assert (!next_vld && !link_vld && !cnt_vld);
    if (kind == BK_IMM)
      assert_imm_always_taken_R2: assert (next_vld && !cnt_vld);
    if (kind == BK_IMM)
      assert_imm_no_count_R4: assert (cnt_out == '0);
    if (link_vld)
      assert_link_return_R3: assert (link_addr - cur_addr == INSN_BYTES);
    if (is_cond && next_vld)
      assert_taken_needs_both_R8: assert (cond_ok && cnt_ok);
    if (cnt_vld)
      assert_count_step_R6: assert (cnt_in - cnt_out == XLEN'(1));
  end
endmodule

// File: tb/br_resolve_unit_test.sv
module br_resolve_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  op_kind;
  logic [23:0] f_li;
  logic [13:0] f_bd;
  logic        f_aa, link_en, mode32;
  logic [4:0]  f_bo, f_bi;
  logic [9:0]  f_xo;
  logic [7:0]  ctx_in, ctx_out;
  logic [63:0] cur_addr, cnt_in, tgt_in;
  logic [3:0]  cr_field;
  logic [63:0] next_addr, link_addr, cnt_out;
  logic        next_vld, link_vld, cnt_vld;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  br_resolve_unit uut (
    .op_kind(op_kind), .f_li(f_li), .f_bd(f_bd), .f_aa(f_aa), .f_bo(f_bo),
    .f_bi(f_bi), .f_xo(f_xo), .link_en(link_en), .mode32(mode32),
    .ctx_in(ctx_in), .cur_addr(cur_addr), .cr_field(cr_field),
    .cnt_in(cnt_in), .tgt_in(tgt_in), .next_addr(next_addr),
    .next_vld(next_vld), .link_addr(link_addr), .link_vld(link_vld),
    .cnt_out(cnt_out), .cnt_vld(cnt_vld), .ctx_out(ctx_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sext4(input logic [63:0] v, input int w);
    logic signed [63:0] t;
    t = $signed(v << (64 - w));
    t = t >>> (64 - w);
    return 64'(t) * 64'd4;
  endfunction

  // Apply one vector and compare every output with the rule-based model
  task automatic run_vec(input logic [1:0] k, input logic [4:0] bo, input logic [4:0] bi,
                         input logic [3:0] crf, input logic [23:0] li, input logic [13:0] bd,
                         input logic aa, input logic lk, input logic m32, input logic [9:0] xo,
                         input logic [63:0] cur, input logic [63:0] cnt, input logic [63:0] tg,
                         input logic [7:0] ctx);
    logic cbit, cond, nz, cok, e_nv, e_lv, e_cv;
    logic [63:0] off, e_na, e_la, e_co;
    @(negedge clk);
    op_kind = k; f_bo = bo; f_bi = bi; cr_field = crf; f_li = li; f_bd = bd;
    f_aa = aa; link_en = lk; mode32 = m32; f_xo = xo; cur_addr = cur;
    cnt_in = cnt; tgt_in = tg; ctx_in = ctx;
    #1;
    cbit = crf[3 - bi[1:0]];
    cond = bo[4] | (cbit == bo[3]);
    nz   = m32 ? (cnt[31:0] != 0) : (cnt != 0);
    cok  = bo[2] | (nz ^ bo[1]);
    off  = (k == 2'd1) ? sext4(64'(li), 24) : sext4(64'(bd), 14);
    e_nv = (k == 2'd1) | ((k >= 2'd2) & cond & cok);
    if (k == 2'd3) e_na = (xo[9] && !xo[5]) ? (cnt & ~64'd3) : (tg & ~64'd3);
    else           e_na = aa ? off : cur + off;
    if (!e_nv) e_na = 64'd0;
    e_lv = (k != 2'd0) & lk;
    e_la = e_lv ? cur + 64'd4 : 64'd0;
    e_cv = (k >= 2'd2) & ~bo[2];
    e_co = e_cv ? cnt - 64'd1 : 64'd0;
    chk("R5 R7 R8 next_vld", 64'(next_vld), 64'(e_nv));
    chk("R2 R9 R10 next_addr", next_addr, e_na);
    chk("R3 link_vld", 64'(link_vld), 64'(e_lv));
    chk("R3 link_addr", link_addr, e_la);
    chk("R4 R6 cnt_vld", 64'(cnt_vld), 64'(e_cv));
    chk("R6 cnt_out", cnt_out, e_co);
    chk("R1 ctx_out", 64'(ctx_out), 64'(ctx));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("[TB] FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] cnts [6];
    op_kind = 2'd0; f_li = '0; f_bd = '0; f_aa = 1'b0; f_bo = '0; f_bi = '0;
    f_xo = '0; link_en = 1'b0; mode32 = 1'b0; ctx_in = '0; cur_addr = '0;
    cr_field = '0; cnt_in = '0; tgt_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset-time idle state
    chk("R1 idle next_vld", 64'(next_vld), 64'd0);
    chk("R1 idle link_vld", 64'(link_vld), 64'd0);
    chk("R1 idle cnt_vld", 64'(cnt_vld), 64'd0);

    cnts[0] = 64'd0; cnts[1] = 64'd1; cnts[2] = 64'h0000_0001_0000_0000;
    cnts[3] = '1;    cnts[4] = 64'hFFFF_FFFF_0000_0000; cnts[5] = 64'h0;

    for (int k = 0; k < 4; k++)
      for (int bo = 0; bo < 32; bo++)
        for (int bi = 0; bi < 4; bi++)
          for (int crf = 0; crf < 16; crf++) begin
            logic [63:0] c;
            c = (bi == 3 && crf[0]) ? {$urandom, $urandom} : cnts[(bo + crf) % 6];
            run_vec(2'(k), 5'(bo), {3'($urandom), 2'(bi)}, 4'(crf), 24'($urandom),
                    14'($urandom), 1'($urandom), 1'($urandom), 1'(crf >> 1),
                    {1'(crf), 3'($urandom), 1'(crf >> 2), 5'($urandom)},
                    {$urandom, $urandom}, c, {$urandom, $urandom}, 8'($urandom));
          end

    // R7 count of one, tested before decrement
    run_vec(2'd2, 5'b10000, 5'd0, 4'h0, '0, 14'd5, 1'b0, 1'b0, 1'b0, '0,
            64'h1000, 64'd1, '0, 8'h11);
    // R7 upper-only count reads zero in 32-bit mode
    run_vec(2'd2, 5'b10010, 5'd0, 4'h0, '0, 14'd5, 1'b0, 1'b0, 1'b1, '0,
            64'h1000, 64'h0000_0002_0000_0000, '0, 8'h22);
    run_vec(2'd2, 5'b10000, 5'd0, 4'h0, '0, 14'd5, 1'b0, 1'b0, 1'b1, '0,
            64'h1000, 64'h0000_0002_0000_0000, '0, 8'h23);
    // R2 most negative displacement, relative wrap and absolute
    run_vec(2'd1, 5'd0, 5'd0, 4'h0, 24'h800000, '0, 1'b0, 1'b1, 1'b0, '0,
            64'h10, '0, '0, 8'h33);
    chk("R2 wrap target", next_addr, 64'hFFFF_FFFF_FE00_0010);
    run_vec(2'd1, 5'd0, 5'd0, 4'h0, 24'h800000, '0, 1'b1, 1'b0, 1'b0, '0,
            64'h10, '0, '0, 8'h34);
    // R9 most negative conditional displacement
    run_vec(2'd2, 5'b10100, 5'd0, 4'h0, '0, 14'h2000, 1'b0, 1'b1, 1'b0, '0,
            64'h4, '0, '0, 8'h44);
    chk("R9 wrap target", next_addr, 64'hFFFF_FFFF_FFFF_8004);
    // R3 return address wraps at the top of the address space
    run_vec(2'd1, 5'd0, 5'd0, 4'h0, 24'd1, '0, 1'b0, 1'b1, 1'b0, '0,
            64'hFFFF_FFFF_FFFF_FFFC, '0, '0, 8'h55);
    // R10 selector differing only in bit 5, then only in bit 9
    run_vec(2'd3, 5'b10100, 5'd0, 4'h0, '0, '0, 1'b0, 1'b0, 1'b0, 10'h200,
            '0, 64'hAAAA_0007, 64'h5555_000B, 8'h66);
    run_vec(2'd3, 5'b10100, 5'd0, 4'h0, '0, '0, 1'b0, 1'b0, 1'b0, 10'h220,
            '0, 64'hAAAA_0007, 64'h5555_000B, 8'h67);
    run_vec(2'd3, 5'b10100, 5'd0, 4'h0, '0, '0, 1'b0, 1'b0, 1'b0, 10'h000,
            '0, 64'hAAAA_0007, 64'h5555_000B, 8'h68);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule